// File: doc/BRIEF.md
# Chained Two-Stage 32-bit Up-Counter

This block builds a 32-bit up-counter out of two identical 16-bit timer units. The lower unit, the leader, counts every enabled clock. On the clock where it passes its own wrap limit and returns to zero, it raises a one-clock update pulse on its trigger output. The upper unit, the follower, has no direct link to the leader's counter. It picks one line from a small bank of internal trigger inputs and treats every cycle in which that line is high as one edge of its own count clock. By default the leader's update pulse sits in the slot the follower selects.

Each half has its own wrap limit, supplied as an input, so the block can serve as a long-period tick source or as a wide free-running time base. Both halves are registered on the same edge and read out side by side. A 32-bit value taken in any cycle is therefore never torn. A one-cycle overflow flag marks the moment the whole 32-bit value returns to zero.

Parameters choose the source that drives the leader's trigger output (update, enable or reset), the follower's trigger slot, and the follower's slave behaviour (external clock, reset, gated or triggered start). The requirements below describe the default: update source, external-clock follower.

Top module: `cascade_timer32`

## Requirements
- R1: A high `rst`, sampled on a clock edge, clears both halves of `count` and `ovf` to zero after that edge, whatever the state of `en`.
- R2: While `en` is high, the lower half (`count[15:0]`) rises by one on each clock. On a clock where it is greater than or equal to `lim_lo`, it returns to 0 instead.
- R3: While `en` is low, `count` holds its value and `ovf` stays low.
- R4: The upper half (`count[31:16]`) changes only on clocks where the lower half wraps. On such a clock it rises by one, or returns to 0 when it is already greater than or equal to `lim_hi`.
- R5: Bits 31:16 of `count` carry the upper half and bits 15:0 the lower half. A carry into the upper half appears in the same cycle as the lower half's return to 0.
- R6: `ovf` is high for exactly the one cycle that follows a clock on which both halves wrap, and `count` reads 0 in that cycle.
- R7: With `lim_lo` equal to 0, the lower half stays at 0 and the upper half advances on every enabled clock.
- R8: If `lim_lo` is lowered below the current lower-half value, the next enabled clock wraps the lower half to 0 and advances the upper half.
- R9: With `lim_hi` equal to 0, the upper half stays at 0 and `ovf` pulses after every lower-half wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global count enable |
| lim_lo | input | 16 | Wrap limit of the lower (leader) half |
| lim_hi | input | 16 | Wrap limit of the upper (follower) half |
| count | output | 32 | Combined count, upper half in bits 31:16 |
| ovf | output | 1 | One-cycle pulse after the full 32-bit value wraps |

## Verification
Two functions can fall in the same cycle. The lower half can wrap at the very clock where the upper half also wraps, which is the overflow case. A wrap limit can also be lowered below the running count just as an enable or a wrap occurs. Both are provoked with tiny limits (1 and 1, 2 and 0, 0 for the lower half) and by random changes of the limits and the enable. A behavioural reference model, run beside the design on every clock, judges the results. It predicts both halves and the overflow flag, and mismatches are reported per half, so a carry that lands one cycle late or a missed simultaneous wrap shows up at once.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    // Source routed onto the leader's trigger output.
    typedef enum logic [1:0] {
        TRGO_RESET  = 2'd0,
        TRGO_ENABLE = 2'd1,
        TRGO_UPDATE = 2'd2
    } trgo_src_e;

    // Behaviour of a timer unit with respect to its selected trigger.
    typedef enum logic [2:0] {
        SLV_FREE    = 3'd0,  // counts its own tick, trigger ignored
        SLV_EXTCLK  = 3'd1,  // each high trigger cycle is one count edge
        SLV_RESET   = 3'd2,  // trigger clears the counter
        SLV_GATED   = 3'd3,  // counts only while trigger is high
        SLV_TRIGGER = 3'd4   // trigger arms the counter, which then runs
    } slave_mode_e;

endpackage

// File: rtl/ctmr_trig_sel.sv
module ctmr_trig_sel #(
    parameter int N   = 4,
    parameter int SEL = 2
) (
    input  logic [N-1:0] itr,
    output logic         trig
);
    localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

    // Walk every slot so all inputs stay referenced for any SEL.
    always_comb begin
        trig = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (SEL_W'(i) == SEL_W'(SEL)) begin
                trig = itr[i];
            end
        end
    end
endmodule

// File: rtl/ctmr_trgo.sv
module ctmr_trgo
    import ctmr_pkg::*;
#(
    parameter trgo_src_e SRC = TRGO_UPDATE
) (
    input  logic rst_evt,
    input  logic en,
    input  logic upd,
    output logic trgo
);
    always_comb begin
        case (SRC)
            TRGO_RESET:  trgo = rst_evt;
            TRGO_ENABLE: trgo = en;
            TRGO_UPDATE: trgo = upd;
            default:     trgo = upd;
        endcase
    end
endmodule

// File: rtl/ctmr_unit.sv
module ctmr_unit
    import ctmr_pkg::*;
#(
    parameter int          W    = 16,
    parameter slave_mode_e MODE = SLV_FREE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         trig,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         upd
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         armed;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic     adv;
    logic     clr;
    logic     at_top;

    always_comb begin
        st_d   = st_q;
        adv    = 1'b0;
        clr    = 1'b0;
        at_top = (st_q.cnt >= limit);
        case (MODE)
            SLV_FREE:   adv = tick;
            SLV_EXTCLK: adv = trig;
            SLV_RESET: begin
                clr = trig;
                adv = tick && !trig;
            end
            SLV_GATED:  adv = tick && trig;
            SLV_TRIGGER: begin
                if (trig) begin
                    st_d.armed = 1'b1;
                end
                adv = tick && (st_q.armed || trig);
            end
            default:    adv = tick;
        endcase
        if (clr) begin
            st_d.cnt = '0;
        end else if (adv) begin
            st_d.cnt = at_top ? '0 : st_q.cnt + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign upd = adv && at_top && !clr && !rst;
endmodule

// File: rtl/cascade_timer32.sv
module cascade_timer32
    import ctmr_pkg::*;
#(
    parameter int          W          = 16,
    parameter int          NUM_ITR    = 4,
    parameter int          LEAD_SLOT  = 2,
    parameter int          FOLLOW_SEL = 2,
    parameter trgo_src_e   LEAD_TRGO  = TRGO_UPDATE,
    parameter slave_mode_e FOLLOW_MODE = SLV_EXTCLK
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [W-1:0]   lim_lo,
    input  logic [W-1:0]   lim_hi,
    output logic [2*W-1:0] count,
    output logic           ovf
);
    localparam int CW = 2 * W;

    typedef struct packed {
        logic ovf;
    } top_st_t;

    logic [W-1:0]       lead_cnt;
    logic [W-1:0]       foll_cnt;
    logic               lead_upd;
    logic               foll_upd;
    logic               m_trgo;
    logic               foll_trig;
    logic [NUM_ITR-1:0] itr_bus;
    top_st_t            top_d, top_q;

    ctmr_unit #(.W(W), .MODE(SLV_FREE)) u_lead (
        .clk  (clk),
        .rst  (rst),
        .tick (en),
        .trig (1'b0),
        .limit(lim_lo),
        .cnt  (lead_cnt),
        .upd  (lead_upd)
    );

    ctmr_trgo #(.SRC(LEAD_TRGO)) u_trgo (
        .rst_evt(rst),
        .en     (en),
        .upd    (lead_upd),
        .trgo   (m_trgo)
    );

    // Internal trigger bank: only the leader's slot is populated.
    for (genvar i = 0; i < NUM_ITR; i++) begin : g_itr
        if (i == LEAD_SLOT) begin : g_lead
            assign itr_bus[i] = m_trgo;
        end else begin : g_idle
            assign itr_bus[i] = 1'b0;
        end
    end

    ctmr_trig_sel #(.N(NUM_ITR), .SEL(FOLLOW_SEL)) u_tsel (
        .itr (itr_bus),
        .trig(foll_trig)
    );

    ctmr_unit #(.W(W), .MODE(FOLLOW_MODE)) u_follow (
        .clk  (clk),
        .rst  (rst),
        .tick (en),
        .trig (foll_trig),
        .limit(lim_hi),
        .cnt  (foll_cnt),
        .upd  (foll_upd)
    );

    always_comb begin
        top_d     = top_q;
        top_d.ovf = lead_upd && foll_upd;
        if (rst) begin
            top_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        top_q <= top_d;
    end

    assign count = CW'({foll_cnt, lead_cnt});
    assign ovf   = top_q.ovf;
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           en,
    input logic [W-1:0]   lim_lo,
    input logic [W-1:0]   lim_hi,
    input logic [2*W-1:0] count,
    input logic           ovf,
    input logic           trgo
);
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    always_comb begin
        if (rst_seen_q == 1'b1) begin
            AST_RESET_ZERO: assert (count == '0 && !ovf); // R1
        end
    end

    AST_LO_STEP: assert property (@(posedge clk) disable iff (rst)
        en && count[W-1:0] < lim_lo |=> count[W-1:0] == $past(count[W-1:0]) + 1'b1); // R2

    AST_LO_WRAP: assert property (@(posedge clk) disable iff (rst)
        en && count[W-1:0] >= lim_lo |=> count[W-1:0] == '0); // R2

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count) && !ovf); // R3

    AST_TRGO_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        trgo |-> en && count[W-1:0] >= lim_lo); // R4

    AST_HI_QUIET: assert property (@(posedge clk) disable iff (rst)
        !trgo |=> $stable(count[2*W-1:W])); // R4

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        en && count[W-1:0] >= lim_lo && count[2*W-1:W] >= lim_hi |=> ovf); // R6

    AST_OVF_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovf |-> count == '0); // R6
endmodule

bind cascade_timer32 ctmr_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .lim_lo(lim_lo),
    .lim_hi(lim_hi),
    .count (count),
    .ovf   (ovf),
    .trgo  (m_trgo)
);

// File: tb/sim_cascade_timer32.sv
module sim_cascade_timer32;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] lim_lo = 16'd5;
    logic [15:0] lim_hi = 16'd3;
    logic [31:0] count;
    logic        ovf;

    int  total = 0;
    int  bad = 0;
    bit  cmp_on = 1'b0;
    bit  done = 1'b0;
    int  m_lo = 0;
    int  m_hi = 0;
    bit  m_ovf = 1'b0;

    always #5 clk = ~clk;

    cascade_timer32 u0 (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .lim_lo(lim_lo),
        .lim_hi(lim_hi),
        .count (count),
        .ovf   (ovf)
    );

    task automatic chk(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Behavioural reference: two wrap counters and a flag.
    always @(posedge clk) begin
        if (rst) begin
            m_lo = 0; m_hi = 0; m_ovf = 1'b0;
        end else if (en) begin
            m_ovf = 1'b0;
            if (m_lo >= int'(lim_lo)) begin
                m_lo = 0;
                if (m_hi >= int'(lim_hi)) begin
                    m_hi = 0;
                    m_ovf = 1'b1;
                end else begin
                    m_hi++;
                end
            end else begin
                m_lo++;
            end
        end else begin
            m_ovf = 1'b0;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(int'(count[15:0]) == m_lo, "R2 lower half vs model", count[15:0], m_lo);
            chk(int'(count[31:16]) == m_hi, "R4 upper half vs model", count[31:16], m_hi);
            chk(ovf == m_ovf, "R6 ovf vs model", ovf, m_ovf);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int h;
        int c;
        int pulses;
        step(3);
        chk(count == 32'd0, "R1 count after reset", count, 0);
        chk(ovf == 1'b0, "R1 ovf after reset", ovf, 0);
        rst = 1'b0;
        cmp_on = 1'b1;

        en = 1'b1;
        step(40);

        // R3: hold while disabled
        c = int'(count);
        en = 1'b0;
        step(5);
        chk(int'(count) == c, "R3 count held", count, c);
        chk(ovf == 1'b0, "R3 ovf low", ovf, 0);

        // R5: carry lands with the lower wrap
        en = 1'b1;
        lim_lo = 16'd3;
        lim_hi = 16'd50;
        for (int i = 0; i < 10; i++) begin
            if (count[15:0] == 16'd3) break;
            step(1);
        end
        h = int'(count[31:16]);
        step(1);
        chk(count[15:0] == 16'd0, "R5 lower half wrapped", count[15:0], 0);
        chk(int'(count[31:16]) == ((h >= 50) ? 0 : h + 1), "R5 carry same cycle",
            count[31:16], (h >= 50) ? 0 : h + 1);

        // R8: limit lowered under the running value
        lim_lo = 16'd200;
        step(60);
        h = int'(count[31:16]);
        lim_lo = 16'd10;
        step(1);
        chk(count[15:0] == 16'd0, "R8 lower half wraps at once", count[15:0], 0);
        chk(int'(count[31:16]) == ((h >= 50) ? 0 : h + 1), "R8 upper half advanced",
            count[31:16], (h >= 50) ? 0 : h + 1);

        // R7: lower limit of zero
        lim_lo = 16'd0;
        lim_hi = 16'd1000;
        step(1);
        h = int'(count[31:16]);
        step(3);
        chk(count[15:0] == 16'd0, "R7 lower half stuck at zero", count[15:0], 0);
        chk(int'(count[31:16]) == h + 3, "R7 upper half per clock", count[31:16], h + 3);

        // R6: both halves wrap on the same clock (limits 1 and 1)
        rst = 1'b1;
        step(1);
        chk(count == 32'd0, "R1 reset with en high", count, 0);
        rst = 1'b0;
        lim_lo = 16'd1;
        lim_hi = 16'd1;
        step(3);
        chk(ovf == 1'b0, "R6 no ovf before double wrap", ovf, 0);
        chk(count == 32'h0001_0001, "R6 count before double wrap", count, 32'h0001_0001);
        step(1);
        chk(ovf == 1'b1, "R6 ovf after double wrap", ovf, 1);
        chk(count == 32'd0, "R6 count zero with ovf", count, 0);
        step(1);
        chk(ovf == 1'b0, "R6 ovf lasts one cycle", ovf, 0);

        // R9: upper limit of zero
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        lim_lo = 16'd2;
        lim_hi = 16'd0;
        pulses = 0;
        for (int i = 0; i < 9; i++) begin
            step(1);
            if (ovf) pulses++;
            chk(count[31:16] == 16'd0, "R9 upper half stays zero", count[31:16], 0);
        end
        chk(pulses == 3, "R9 ovf per lower wrap", pulses, 3);

        // Longer run with natural wraps
        lim_lo = 16'd300;
        lim_hi = 16'd5;
        step(3000);

        // Random enable and limit changes
        for (int i = 0; i < 4000; i++) begin
            en = ($urandom % 4) != 0;
            if ($urandom % 16 == 0) lim_lo = 16'($urandom % 8);
            if ($urandom % 32 == 0) lim_hi = 16'($urandom % 4);
            step(1);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule